// File: doc/BRIEF.md
# GPIO Pin Interrupt Controller

This block watches twelve general-purpose input pins and turns selected transitions or levels on them into one shared interrupt request. Each pin is first brought into the local clock domain by a two-stage synchroniser. A per-pin detector then compares the synchronised value with its value one clock earlier, according to a three-bit trigger code. When a pin is enabled and its condition occurs, the event is latched into a status bit. That bit stays set until software writes a one to the matching bit of the clear register.

Software reaches the block through a small register bus. The bus has a write strobe, a 3-bit word address, write data, and read data that is decoded combinationally from the address. Besides the enable, status and two trigger-mode registers, there are three write-one-per-pin command words: one clears status, one unmasks pins and one masks pins. A read-only view shows the current mask.

The interrupt output comes from a two-state line sequencer. State `LINE_QUIET` moves to `LINE_RAISED` (transition *raise*) on any clock where some pin is latched, enabled and unmasked. `LINE_RAISED` moves back to `LINE_QUIET` (transition *drop*) once no such pin is left. Otherwise each state holds (transitions *idle* and *hold*). The output is high exactly in `LINE_RAISED`.

Top module: `gpio_irq_ctrl`

## Requirements
- R1: After reset, the enable register, the status register and every trigger code read 0, the mask view reads 0xFFF (all pins masked), and `irq_o` is low.
- R2: A pin change that is set up before clock edge k is latched into status at edge k+2, and no earlier. This reflects two synchroniser stages ahead of detection.
- R3: Pin n's trigger code sits in bits [4m+2:4m] of a mode word. Pins 0-7 use address 5 with m = n. Pins 8-11 use address 6 with m = n-8. The codes are: 0 = falling edge, 1 = rising edge, 2 = level high, 3 = level low, 4 = either edge.
- R4: Trigger codes 5, 6 and 7 never set status, whatever the pin does.
- R5: The enable register (address 0, read/write, bit n = pin n) gates latching. An event on a disabled pin sets nothing, and enabling the pin later does not recover that event.
- R6: Writing to address 2 clears each status bit (address 1, read only) whose data bit is 1. Zero bits leave status unchanged.
- R7: In a level mode, a status bit that is cleared while the level is still active reads set again, because a new event on the same clock takes priority over the clear.
- R8: Writing to address 3 unmasks each pin whose data bit is 1. Writing to address 4 masks each such pin. Zero bits have no effect on the mask. Address 7 reads the mask.
- R9: `irq_o` is registered. It equals, one clock later, the OR over pins of status AND enable AND NOT mask.
- R10: A latched status bit holds until it is cleared. Disabling or masking the pin removes it from `irq_o` but does not clear it.
- R11: Addresses 2, 3 and 4 read as zero. Unused bits of the mode words (bit 3 of each nibble, and nibbles beyond pin 11) read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pin_i | input | 12 | Asynchronous pin inputs |
| bus_we_i | input | 1 | Register write strobe, one clock per write |
| bus_addr_i | input | 3 | Register word address |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data for `bus_addr_i`, combinational |
| irq_o | output | 1 | Shared interrupt request |

## Verification
The hardest case to reach from the ports is a clear write that lands on the same clock as a fresh level event. Software cannot see the synchroniser, so the pin must be driven exactly two clocks ahead, and the level must still be active when the clear arrives. Directed steps build this case by raising a pin in level-high mode and then issuing the clear while the pin stays high. Random phases then toggle pins sparsely, so that levels persist across many bus writes, and they rewrite trigger codes, including the reserved ones. A bench reference model follows status and `irq_o` every clock throughout.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;

    // Register word addresses. Mode word r sits at ADR_MODE0 + r.
    localparam int unsigned  REG_AW       = 3;
    localparam logic [2:0]   ADR_ENABLE   = 3'd0;
    localparam logic [2:0]   ADR_STATUS   = 3'd1;
    localparam logic [2:0]   ADR_CLEAR    = 3'd2;
    localparam logic [2:0]   ADR_UNMASK   = 3'd3;
    localparam logic [2:0]   ADR_MASK     = 3'd4;
    localparam logic [2:0]   ADR_MODE0    = 3'd5;
    localparam logic [2:0]   ADR_MASKVIEW = 3'd7;

    // Trigger code layout: 3 code bits at a 4-bit pitch
    localparam int unsigned  CODE_W       = 3;
    localparam int unsigned  CODE_PITCH   = 4;

    localparam logic [2:0]   TRIG_FALL    = 3'd0;
    localparam logic [2:0]   TRIG_RISE    = 3'd1;
    localparam logic [2:0]   TRIG_HIGH    = 3'd2;
    localparam logic [2:0]   TRIG_LOW     = 3'd3;
    localparam logic [2:0]   TRIG_BOTH    = 3'd4;

    typedef enum logic {
        LINE_QUIET  = 1'b0,
        LINE_RAISED = 1'b1
    } line_state_t;

endpackage

// File: rtl/gpio_irq_sync.sv
// Two-stage synchroniser plus one history stage for edge detection (R2).
module gpio_irq_sync #(
    parameter int unsigned W = 12
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic [W-1:0] raw_i,
    output logic [W-1:0] cur_o,
    output logic [W-1:0] prev_o
);

    logic [W-1:0] meta_q;
    logic [W-1:0] cur_q;
    logic [W-1:0] prev_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            meta_q <= '0;
            cur_q  <= '0;
            prev_q <= '0;
        end else begin
            meta_q <= raw_i;
            cur_q  <= meta_q;
            prev_q <= cur_q;
        end
    end

    assign cur_o  = cur_q;
    assign prev_o = prev_q;

endmodule

// File: rtl/gpio_irq_detect.sv
// Per-pin trigger decode (R3, R4).
module gpio_irq_detect
    import gpio_irq_pkg::*;
#(
    parameter int unsigned PINS = 12
) (
    input  logic [PINS-1:0]        cur_i,
    input  logic [PINS-1:0]        prev_i,
    input  logic [CODE_W*PINS-1:0] mode_i,
    output logic [PINS-1:0]        hit_o
);

    for (genvar g = 0; g < PINS; g++) begin : g_pin
        logic [CODE_W-1:0] code;
        logic              rise;
        logic              fall;
        logic              hit;

        assign code = mode_i[g*CODE_W +: CODE_W];
        assign rise = cur_i[g] & ~prev_i[g];
        assign fall = ~cur_i[g] & prev_i[g];

        always_comb begin
            case (code)
                TRIG_FALL: hit = fall;
                TRIG_RISE: hit = rise;
                TRIG_HIGH: hit = cur_i[g];
                TRIG_LOW:  hit = ~cur_i[g];
                TRIG_BOTH: hit = rise | fall;
                default:   hit = 1'b0;   // R4: codes 5..7 reserved
            endcase
        end

        assign hit_o[g] = hit;
    end

endmodule

// File: rtl/gpio_irq_regs.sv
// Register file: enable, mask, trigger codes, latched status, read mux.
module gpio_irq_regs
    import gpio_irq_pkg::*;
#(
    parameter int unsigned PINS = 12,
    parameter int unsigned DW   = 32
) (
    input  logic                   clk_i,
    input  logic                   rst_ni,
    input  logic                   we_i,
    input  logic [REG_AW-1:0]      addr_i,
    input  logic [DW-1:0]          wdata_i,
    input  logic [PINS-1:0]        hit_i,
    output logic [DW-1:0]          rdata_o,
    output logic [PINS-1:0]        en_o,
    output logic [PINS-1:0]        st_o,
    output logic [PINS-1:0]        mask_o,
    output logic [CODE_W*PINS-1:0] mode_o
);

    localparam int unsigned PER_WORD = DW / CODE_PITCH;
    localparam int unsigned N_WORDS  = (PINS + PER_WORD - 1) / PER_WORD;

    logic [PINS-1:0]   en_q;
    logic [PINS-1:0]   st_q;
    logic [PINS-1:0]   mask_q;
    logic [CODE_W-1:0] mode_q [PINS];
    logic [PINS-1:0]   wbits;
    logic [PINS-1:0]   clr_bits;
    logic [DW-1:0]     mode_rd [N_WORDS];
    logic              unused_wdata;

    assign wbits        = wdata_i[PINS-1:0];
    assign unused_wdata = ^wdata_i;
    // R6: write-one clear of status
    assign clr_bits     = (we_i && addr_i == ADR_CLEAR) ? wbits : '0;

    // R5, R1: enable register, resets to zero
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)                              en_q <= '0;
        else if (we_i && addr_i == ADR_ENABLE)    en_q <= wbits;
    end

    // R8: mask, set and cleared by write-one commands; all masked at reset
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)                              mask_q <= '1;
        else if (we_i && addr_i == ADR_UNMASK)    mask_q <= mask_q & ~wbits;
        else if (we_i && addr_i == ADR_MASK)      mask_q <= mask_q | wbits;
    end

    // R3: trigger codes packed at a 4-bit pitch over consecutive words
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            for (int p = 0; p < PINS; p++) mode_q[p] <= '0;
        end else if (we_i) begin
            for (int p = 0; p < PINS; p++) begin
                if (int'(addr_i) == int'(ADR_MODE0) + p / PER_WORD)
                    mode_q[p] <= wdata_i[(p % PER_WORD)*CODE_PITCH +: CODE_W];
            end
        end
    end

    // R6, R7, R10: new events win over a clear on the same clock
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= (st_q & ~clr_bits) | (hit_i & en_q);
    end

    // R11: mode words read back with spare bits at zero
    always_comb begin
        for (int r = 0; r < N_WORDS; r++) mode_rd[r] = '0;
        for (int p = 0; p < PINS; p++)
            mode_rd[p / PER_WORD][(p % PER_WORD)*CODE_PITCH +: CODE_W] = mode_q[p];
    end

    // Read mux; command words (clear, unmask, mask) read zero
    always_comb begin
        rdata_o = '0;
        unique case (addr_i)
            ADR_ENABLE:   rdata_o[PINS-1:0] = en_q;
            ADR_STATUS:   rdata_o[PINS-1:0] = st_q;
            ADR_MASKVIEW: rdata_o[PINS-1:0] = mask_q;
            default: begin
                for (int r = 0; r < N_WORDS; r++)
                    if (int'(addr_i) == int'(ADR_MODE0) + r) rdata_o = mode_rd[r];
            end
        endcase
    end

    always_comb begin
        for (int p = 0; p < PINS; p++) mode_o[p*CODE_W +: CODE_W] = mode_q[p];
    end

    assign en_o   = en_q;
    assign st_o   = st_q;
    assign mask_o = mask_q;

endmodule

// File: rtl/gpio_irq_line.sv
// Shared interrupt line sequencer (R9).
module gpio_irq_line
    import gpio_irq_pkg::*;
#(
    parameter int unsigned PINS = 12
) (
    input  logic            clk_i,
    input  logic            rst_ni,
    input  logic [PINS-1:0] st_i,
    input  logic [PINS-1:0] en_i,
    input  logic [PINS-1:0] mask_i,
    output logic            irq_o
);

    line_state_t state_q;
    line_state_t state_d;
    logic        pend;

    assign pend = |(st_i & en_i & ~mask_i);

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) state_q <= LINE_QUIET;
        else         state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            LINE_QUIET:  if (pend)  state_d = LINE_RAISED;   // raise
            LINE_RAISED: if (!pend) state_d = LINE_QUIET;    // drop
            default:                state_d = LINE_QUIET;
        endcase
    end

    always_comb begin
        irq_o = (state_q == LINE_RAISED);
    end

endmodule

// File: rtl/gpio_irq_ctrl.sv
module gpio_irq_ctrl
    import gpio_irq_pkg::*;
#(
    parameter int unsigned PINS = 12,
    parameter int unsigned DW   = 32
) (
    input  logic                  clk_i,
    input  logic                  rst_ni,
    input  logic [PINS-1:0]       pin_i,
    input  logic                  bus_we_i,
    input  logic [REG_AW-1:0]     bus_addr_i,
    input  logic [DW-1:0]         bus_wdata_i,
    output logic [DW-1:0]         bus_rdata_o,
    output logic                  irq_o
);

    logic [PINS-1:0]        cur_w;
    logic [PINS-1:0]        prev_w;
    logic [PINS-1:0]        hit_w;
    logic [PINS-1:0]        en_w;
    logic [PINS-1:0]        st_w;
    logic [PINS-1:0]        mask_w;
    logic [CODE_W*PINS-1:0] mode_w;

    gpio_irq_sync #(.W(PINS)) i_sync (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .raw_i  (pin_i),
        .cur_o  (cur_w),
        .prev_o (prev_w)
    );

    gpio_irq_detect #(.PINS(PINS)) i_detect (
        .cur_i  (cur_w),
        .prev_i (prev_w),
        .mode_i (mode_w),
        .hit_o  (hit_w)
    );

    gpio_irq_regs #(.PINS(PINS), .DW(DW)) i_regs (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .we_i    (bus_we_i),
        .addr_i  (bus_addr_i),
        .wdata_i (bus_wdata_i),
        .hit_i   (hit_w),
        .rdata_o (bus_rdata_o),
        .en_o    (en_w),
        .st_o    (st_w),
        .mask_o  (mask_w),
        .mode_o  (mode_w)
    );

    gpio_irq_line #(.PINS(PINS)) i_line (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .st_i   (st_w),
        .en_i   (en_w),
        .mask_i (mask_w),
        .irq_o  (irq_o)
    );

endmodule

// File: rtl/gpio_irq_ctrl_chk.sv
module gpio_irq_ctrl_chk
    import gpio_irq_pkg::*;
#(
    parameter int unsigned PINS = 12,
    parameter int unsigned DW   = 32
) (
    input logic                   clk_i,
    input logic                   rst_ni,
    input logic                   bus_we_i,
    input logic [REG_AW-1:0]      bus_addr_i,
    input logic [DW-1:0]          bus_wdata_i,
    input logic                   irq_o,
    input logic [PINS-1:0]        en_w,
    input logic [PINS-1:0]        st_w,
    input logic [PINS-1:0]        mask_w,
    input logic [CODE_W*PINS-1:0] mode_w
);

    // R1
    reset_state_chk: assert property (@(posedge clk_i)
        !rst_ni |=> (en_w == '0 && st_w == '0 && mask_w == '1 && !irq_o));

    // R9
    line_raise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (|(st_w & en_w & ~mask_w)) |=> irq_o);

    // R9
    line_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(|(st_w & en_w & ~mask_w)) |=> !irq_o);

    for (genvar g = 0; g < PINS; g++) begin : g_pin
        // R5
        gate_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (!en_w[g] && !st_w[g]) |=> !st_w[g]);

        // R4
        reserved_code_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (mode_w[g*CODE_W +: CODE_W] >= 3'd5 && !st_w[g]) |=> !st_w[g]);

        // R10
        status_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (st_w[g] && !(bus_we_i && bus_addr_i == ADR_CLEAR && bus_wdata_i[g]))
            |=> st_w[g]);

        // R8
        unmask_cmd_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (bus_we_i && bus_addr_i == ADR_UNMASK && bus_wdata_i[g]) |=> !mask_w[g]);

        // R8
        mask_cmd_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (bus_we_i && bus_addr_i == ADR_MASK && bus_wdata_i[g]) |=> mask_w[g]);
    end

endmodule

bind gpio_irq_ctrl gpio_irq_ctrl_chk #(.PINS(PINS), .DW(DW)) i_chk (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .bus_we_i    (bus_we_i),
    .bus_addr_i  (bus_addr_i),
    .bus_wdata_i (bus_wdata_i),
    .irq_o       (irq_o),
    .en_w        (en_w),
    .st_w        (st_w),
    .mask_w      (mask_w),
    .mode_w      (mode_w)
);

// File: tb/test_gpio_irq_ctrl.sv
`timescale 1ns/1ps
module test_gpio_irq_ctrl;

    localparam int N = 12;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [N-1:0] pins = '0;
    logic        we = 1'b0;
    logic [2:0]  addr = 3'd0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        irq;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 0;

    always #10 clk = ~clk;   // 50 MHz

    gpio_irq_ctrl i_gpio_irq_ctrl (
        .clk_i       (clk),
        .rst_ni      (rst_n),
        .pin_i       (pins),
        .bus_we_i    (we),
        .bus_addr_i  (addr),
        .bus_wdata_i (wdata),
        .bus_rdata_o (rdata),
        .irq_o       (irq)
    );

    // Reference model built from the requirements
    logic [N-1:0] m_s1, m_s2, m_d, m_en, m_st, m_mask;
    logic [2:0]   m_mode [N];
    logic         m_irq;

    function automatic logic trig(input logic [2:0] c, input logic cur, input logic prv);
        case (c)
            3'd0:    return !cur && prv;
            3'd1:    return cur && !prv;
            3'd2:    return cur;
            3'd3:    return !cur;
            3'd4:    return cur != prv;
            default: return 1'b0;
        endcase
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_s1 <= '0; m_s2 <= '0; m_d <= '0;
            m_en <= '0; m_st <= '0; m_mask <= '1; m_irq <= 1'b0;
            for (int p = 0; p < N; p++) m_mode[p] <= 3'd0;
        end else begin : step
            logic [N-1:0] ev;
            logic [N-1:0] clr;
            for (int p = 0; p < N; p++) ev[p] = trig(m_mode[p], m_s2[p], m_d[p]);
            clr = (we && addr == 3'd2) ? wdata[N-1:0] : '0;
            m_irq <= |(m_st & m_en & ~m_mask);
            m_st  <= (m_st & ~clr) | (ev & m_en);
            if (we && addr == 3'd0) m_en <= wdata[N-1:0];
            if (we && addr == 3'd3) m_mask <= m_mask & ~wdata[N-1:0];
            if (we && addr == 3'd4) m_mask <= m_mask | wdata[N-1:0];
            for (int p = 0; p < N; p++)
                if (we && int'(addr) == 5 + p / 8) m_mode[p] <= wdata[(p % 8)*4 +: 3];
            m_d <= m_s2; m_s2 <= m_s1; m_s1 <= pins;
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        we = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        we = 1'b0;
    endtask

    task automatic rd(input string req, input logic [2:0] a, input logic [31:0] exp);
        addr = a;
        #1;
        chk(req, rdata, exp);
    endtask

    task automatic finish_run();
        $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=hung expected=done");
            finish_run();
        end
    end

    initial begin
        void'($urandom(32'd20110630));
        tick(3);
        rst_n = 1'b1;

        // R1 reset state, R11 command words read zero
        rd("R1 enable",  3'd0, 32'h0);
        rd("R1 status",  3'd1, 32'h0);
        rd("R1 mask",    3'd7, 32'hFFF);
        rd("R1 mode0",   3'd5, 32'h0);
        rd("R1 mode1",   3'd6, 32'h0);
        chk("R1 irq", {31'd0, irq}, 32'd0);
        rd("R11 clear reads 0",  3'd2, 32'h0);
        rd("R11 unmask reads 0", 3'd3, 32'h0);
        rd("R11 mask reads 0",   3'd4, 32'h0);

        // R2 latency with pin0 level high
        wr(3'd5, 32'h2); wr(3'd0, 32'h1); wr(3'd3, 32'h1);
        rd("R8 unmask pin0", 3'd7, 32'hFFE);
        pins[0] = 1'b1;
        tick(1); rd("R2 edge k", 3'd1, 32'h0);
        tick(1); rd("R2 edge k+1", 3'd1, 32'h0);
        tick(1); rd("R2 edge k+2", 3'd1, 32'h1);
        chk("R9 not yet", {31'd0, irq}, 32'd0);
        tick(1); chk("R9 raised", {31'd0, irq}, 32'd1);

        // R7 clear while level active
        wr(3'd2, 32'h1);
        rd("R7 re-set after clear", 3'd1, 32'h1);
        pins[0] = 1'b0;
        tick(3);
        rd("R10 latched", 3'd1, 32'h1);
        wr(3'd2, 32'h1);
        rd("R6 cleared", 3'd1, 32'h0);
        tick(1);
        rd("R6 stays clear", 3'd1, 32'h0);
        chk("R9 dropped", {31'd0, irq}, 32'd0);

        // R3 falling edge on pin 9 (mode word 6, nibble 1)
        wr(3'd0, 32'h201);
        pins[9] = 1'b1; tick(4);
        rd("R3 falling ignores rise", 3'd1, 32'h0);
        pins[9] = 1'b0; tick(4);
        rd("R3 falling", 3'd1, 32'h200);
        tick(5);
        rd("R10 holds", 3'd1, 32'h200);
        chk("R8 masked no irq", {31'd0, irq}, 32'd0);
        wr(3'd3, 32'h200); tick(1);
        chk("R8 unmasked irq", {31'd0, irq}, 32'd1);
        wr(3'd4, 32'h200); tick(1);
        chk("R8 mask set irq", {31'd0, irq}, 32'd0);
        rd("R8 mask view", 3'd7, 32'hFFE);
        wr(3'd3, 32'h200); tick(1);
        chk("R8 unmask again", {31'd0, irq}, 32'd1);
        wr(3'd0, 32'h1); tick(1);
        chk("R10 disabled no irq", {31'd0, irq}, 32'd0);
        rd("R10 disabled keeps status", 3'd1, 32'h200);
        wr(3'd2, 32'h001);
        rd("R6 zero bits no effect", 3'd1, 32'h200);
        wr(3'd2, 32'h200);
        rd("R6 clear bit9", 3'd1, 32'h0);

        // R4 reserved codes on pin 3
        wr(3'd5, 32'h5002); wr(3'd0, 32'h209);
        rd("R11 mode readback", 3'd5, 32'h5002);
        pins[3] = 1'b1; tick(4); pins[3] = 1'b0; tick(4);
        rd("R4 code5", 3'd1, 32'h0);
        wr(3'd5, 32'h7002);
        pins[3] = 1'b1; tick(4); pins[3] = 1'b0; tick(4);
        rd("R4 code7", 3'd1, 32'h0);
        wr(3'd5, 32'hFFFF_FFFF);
        rd("R11 mode0 spare bits", 3'd5, 32'h7777_7777);
        wr(3'd6, 32'hFFFF_FFFF);
        rd("R11 mode1 spare bits", 3'd6, 32'h0000_7777);
        wr(3'd6, 32'h0);

        // R3 both / rising / level low, R5 disabled pin4
        wr(3'd5, 32'h3141_0000);
        wr(3'd0, 32'h060);
        pins[4] = 1'b1; pins[5] = 1'b1; pins[6] = 1'b1; tick(4);
        rd("R3 both+rising on rise, R5 pin4 gated", 3'd1, 32'h060);
        wr(3'd0, 32'h070); tick(2);
        rd("R5 no late event", 3'd1, 32'h060);
        wr(3'd2, 32'h060);
        pins[5] = 1'b0; pins[6] = 1'b0; tick(4);
        rd("R3 both on fall", 3'd1, 32'h020);
        wr(3'd2, 32'hFFF);
        wr(3'd0, 32'h080); tick(1);
        rd("R3 level low", 3'd1, 32'h080);
        pins[7] = 1'b1; tick(3);
        wr(3'd2, 32'h080); tick(1);
        rd("R3 level low inactive", 3'd1, 32'h0);
        wr(3'd0, 32'h0);

        // Random phase against the model (R2..R10)
        for (int i = 0; i < 4000; i++) begin
            int r;
            we = 1'b0; addr = 3'd1; #1;
            chk("R6 R7 R10 status vs model", rdata, {20'd0, m_st});
            chk("R9 irq vs model", {31'd0, irq}, {31'd0, m_irq});
            if ($urandom % 8 == 0) pins[$urandom % N] ^= 1'b1;
            r = int'($urandom % 16);
            if (r < 6) begin
                we = 1'b1;
                case (r)
                    0: begin addr = 3'd0; wdata = $urandom; end
                    1: begin addr = 3'd2; wdata = $urandom; end
                    2: begin addr = 3'd3; wdata = $urandom; end
                    3: begin addr = 3'd4; wdata = $urandom; end
                    4: begin addr = 3'd5; wdata = $urandom; end
                    default: begin addr = 3'd6; wdata = $urandom; end
                endcase
            end
            @(negedge clk);
            we = 1'b0;
        end

        done = 1;
        finish_run();
    end

endmodule